// File: doc/BRIEF.md
# Paged Host Register Front End with Interrupt Gating

This block is the register window that a host uses to drive a small network controller. The host reaches it through a 4-bit offset and one byte of data, with separate write and read strobes. The lower eight offsets never change. The upper eight offsets form a window whose contents depend on a page number that the host writes at offset 1. Offset 0 has a different role on each access direction. A write there issues one-shot commands to the MAC logic. A read there returns a live status byte that the MAC supplies.

The block collects event pulses from the MAC into a sticky interrupt status byte. The host clears that byte by writing 1 to each bit it wants cleared. A per-event mask byte sits in the window on page 1. A global register at offset 7 reports whether the network side and a second on-card function have an interrupt pending, and lets the host mask each of the two separately. The single host interrupt line is built from these two levels of masking and an enable latch that a command sets. A soft-reset command returns the programmable state to its reset values.

Top module: `hostRegFront`

## Requirements
- R1: Offsets 0 to 7 give the same result on every page. Offset 1 is a read/write page register that resets to 0x00. Offsets 8 to 15 are decoded using the page register value.
- R2: A read of offset 0 returns the `macStatus` input. A write to offset 0 never changes what a read of offset 0 returns.
- R3: A write to offset 0 drives wrData[6:0] onto `cmdPulse` for exactly the one cycle that follows the write edge. `cmdPulse` is 0 at every other time. wrData bit 7 has no effect. The bit meanings are: bit0 start transmit, bit1 soft reset, bit2 enable interrupts, bit3 force interrupt, bit4 clear FIFO, bit5 clear receive overrun, bit6 restart transmit.
- R4: Offset 6 is the interrupt status byte. The bits are: bit0 transmit overflow, bit1 packet sent, bit2 MAC event, bit4 early receive, bit5 packet received, bit6 receive reject, bit7 forced. Bit 3 always reads 0. A 1 on `evtPulse[i]` at a clock edge sets status bit i, and the bit stays set. A write to offset 6 clears each bit that is written as 1 and changes nothing else. If a set and a clear of the same bit fall on the same edge, the set wins.
- R5: The event mask byte is read/write at page 1, offset 12. It resets to 0x00 and uses the same bit positions as the status byte.
- R6: Offset 7 reads as {4'b0, sfMask, sfIrqIn, ethMask, ethPending}. Here ethPending = enableLatch AND (status AND mask is nonzero). A write to offset 7 sets ethMask from bit 1 and sfMask from bit 3. Bits 0 and 2 are read-only.
- R7: `hostIrq` = (ethPending AND NOT ethMask) OR (sfIrqIn AND NOT sfMask). It is driven from register state and the `sfIrqIn` input only, with no clocked delay.
- R8: A force-interrupt command sets status bit 7 at the clock edge that ends its `cmdPulse` cycle.
- R9: The interrupt-enable latch resets to 0. It is set by the enable-interrupts command and cleared only by hardware reset or a soft-reset command. While it is 0, ethPending reads 0.
- R10: A soft-reset command clears the page register, the status byte, the event mask, the enable latch and both global mask bits. The clear takes place at the edge that ends its `cmdPulse` cycle and takes priority over events, commands and register writes on that edge.
- R11: A read of offsets 2 to 5, or of any paged offset other than page 1 offset 12, returns 0x00. A write to any of those offsets changes no state.
- R12: Read data is registered. `rdData` loads the addressed value at each edge where `rdEn` is 1 and otherwise holds its value. It resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| evtPulse | input | 8 | Event pulses from the MAC, one bit per status position |
| macStatus | input | 8 | Live MAC status returned on reads of offset 0 |
| sfIrqIn | input | 1 | Interrupt pending level from the second function |
| cmdPulse | output | 7 | One-cycle command action pulses |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
The interrupt gating is checked with a full sweep of all 256 event-mask values against a fixed status byte. After that, a set of status patterns is checked under an all-ones mask, and all 16 global-register values are checked with the second-function input both high and low. This separates errors at the per-event level from errors at the per-function level. Every page value from 0 to 255 is read across all eight windowed offsets. This catches page decoding that is too broad or too narrow, and any leak of a windowed write into a fixed register. Separate tests check each single command bit, a set and a clear of the same status bit on one edge, and a soft reset that coincides with an incoming event. These tests check the one-cycle pulse width and the priority rules.

// File: rtl/regFrontPkg.sv
package regFrontPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int ACT_W  = 7;

  localparam int ACT_TX     = 0;
  localparam int ACT_RESET  = 1;
  localparam int ACT_INTEN  = 2;
  localparam int ACT_FORCE  = 3;

  localparam int ISR_FORCE_BIT = 7;
  localparam logic [DATA_W-1:0] ISR_IMPL = 8'hF7;

  localparam int GIR_ETH_MASK_BIT = 1;
  localparam int GIR_SF_MASK_BIT  = 3;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_PAGE = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_ISR  = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_GIR  = 4'd7;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_STAT,
    SEL_PAGE,
    SEL_ISR,
    SEL_GIR,
    SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic              wrPage;
    logic              wrMask;
    logic              wrGir;
    logic              clrIsr;
    logic [DATA_W-1:0] wData;
    rdSel_e            rdSel;
    logic              rdCap;
    logic [ACT_W-1:0]  act;
  } strobes_t;
endpackage

// File: rtl/regFrontCtrl.sv
module regFrontCtrl
  import regFrontPkg::*;
#(
  parameter int MASK_PAGE   = 1,
  parameter int MASK_OFFSET = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] pageQ,
  output strobes_t          stb
);
  localparam logic [DATA_W-1:0] MASK_PAGE_V = DATA_W'(MASK_PAGE);
  localparam logic [ADDR_W-1:0] MASK_OFF_V  = ADDR_W'(MASK_OFFSET);

  logic             upperHalf;
  logic             maskHit;
  rdSel_e           selNow;
  logic [ACT_W-1:0] actQ;

  assign upperHalf = regAddr[ADDR_W-1];
  assign maskHit   = upperHalf && (pageQ == MASK_PAGE_V) && (regAddr == MASK_OFF_V);

  always_comb begin
    selNow = SEL_ZERO;
    if (maskHit) begin
      selNow = SEL_MASK;
    end else if (!upperHalf) begin
      case (regAddr)
        OFF_CMD:  selNow = SEL_STAT;
        OFF_PAGE: selNow = SEL_PAGE;
        OFF_ISR:  selNow = SEL_ISR;
        OFF_GIR:  selNow = SEL_GIR;
        default:  selNow = SEL_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ <= '0;
    end else if (wrEn && (regAddr == OFF_CMD)) begin
      actQ <= wrData[ACT_W-1:0];
    end else begin
      actQ <= '0;
    end
  end

  always_comb begin
    stb        = '0;
    stb.wData  = wrData;
    stb.wrPage = wrEn && (regAddr == OFF_PAGE);
    stb.clrIsr = wrEn && (regAddr == OFF_ISR);
    stb.wrGir  = wrEn && (regAddr == OFF_GIR);
    stb.wrMask = wrEn && maskHit;
    stb.rdSel  = selNow;
    stb.rdCap  = rdEn;
    stb.act    = actQ;
  end
endmodule

// File: rtl/regFrontData.sv
module regFrontData
  import regFrontPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic [DATA_W-1:0] macStatus,
  input  logic              sfIrqIn,
  output logic [DATA_W-1:0] pageQ,
  output logic [DATA_W-1:0] rdData,
  output logic              hostIrq
);
  logic [DATA_W-1:0] isrQ;
  logic [DATA_W-1:0] maskQ;
  logic              enLatch;
  logic              ethMask;
  logic              sfMask;
  logic              softRst;
  logic              ethPend;
  logic [DATA_W-1:0] isrNext;
  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] forceBits;
  logic [DATA_W-1:0] girView;
  logic [DATA_W-1:0] rdMux;

  assign softRst = stb.act[ACT_RESET];
  assign ethPend = enLatch && ((isrQ & maskQ) != '0);
  assign hostIrq = (ethPend && !ethMask) || (sfIrqIn && !sfMask);

  always_comb begin
    clrBits   = stb.clrIsr ? stb.wData : '0;
    forceBits = '0;
    forceBits[ISR_FORCE_BIT] = stb.act[ACT_FORCE];
    isrNext = ((isrQ & ~clrBits) | evtPulse | forceBits) & ISR_IMPL;
  end

  always_comb begin
    girView    = '0;
    girView[0] = ethPend;
    girView[GIR_ETH_MASK_BIT] = ethMask;
    girView[2] = sfIrqIn;
    girView[GIR_SF_MASK_BIT]  = sfMask;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_STAT: rdMux = macStatus;
      SEL_PAGE: rdMux = pageQ;
      SEL_ISR:  rdMux = isrQ;
      SEL_GIR:  rdMux = girView;
      SEL_MASK: rdMux = maskQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ   <= '0;
      isrQ    <= '0;
      maskQ   <= '0;
      enLatch <= 1'b0;
      ethMask <= 1'b0;
      sfMask  <= 1'b0;
    end else if (softRst) begin
      pageQ   <= '0;
      isrQ    <= '0;
      maskQ   <= '0;
      enLatch <= 1'b0;
      ethMask <= 1'b0;
      sfMask  <= 1'b0;
    end else begin
      isrQ <= isrNext;
      if (stb.wrPage) pageQ <= stb.wData;
      if (stb.wrMask) maskQ <= stb.wData;
      if (stb.act[ACT_INTEN]) enLatch <= 1'b1;
      if (stb.wrGir) begin
        ethMask <= stb.wData[GIR_ETH_MASK_BIT];
        sfMask  <= stb.wData[GIR_SF_MASK_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdCap) begin
      rdData <= rdMux;
    end
  end
endmodule

// File: rtl/hostRegFront.sv
module hostRegFront
  import regFrontPkg::*;
#(
  parameter int MASK_PAGE   = 1,
  parameter int MASK_OFFSET = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic [DATA_W-1:0] macStatus,
  input  logic              sfIrqIn,
  output logic [ACT_W-1:0]  cmdPulse,
  output logic              hostIrq
);
  strobes_t          stb;
  logic [DATA_W-1:0] pageQ;

  regFrontCtrl #(
    .MASK_PAGE  (MASK_PAGE),
    .MASK_OFFSET(MASK_OFFSET)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .pageQ  (pageQ),
    .stb    (stb)
  );

  regFrontData u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .evtPulse (evtPulse),
    .macStatus(macStatus),
    .sfIrqIn  (sfIrqIn),
    .pageQ    (pageQ),
    .rdData   (rdData),
    .hostIrq  (hostIrq)
  );

  assign cmdPulse = stb.act;
endmodule

// File: rtl/regFrontChk.sv
module regFrontChk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] regAddr,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic [7:0] macStatus,
  input logic       sfIrqIn,
  input logic [6:0] cmdPulse,
  input logic       hostIrq
);
  // R3: a command pulse only ever follows a write to offset 0
  a_r3_pulse_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != 7'd0) |-> $past(wrEn && (regAddr == 4'd0)));

  // R12: read data holds when no read strobe was given
  a_r12_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData));

  // R2: offset 0 reads return the MAC status sampled at the read edge
  a_r2_status_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && (regAddr == 4'd0)) |-> (rdData == $past(macStatus)));

  // R11: offsets 2 to 5 always read as zero
  a_r11_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && (regAddr >= 4'd2) && (regAddr <= 4'd5)) |-> (rdData == 8'h00));

  // R10: after soft reset only an unmasked second-function request can raise the line
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdPulse[1]) |-> (hostIrq == sfIrqIn));
endmodule

bind hostRegFront regFrontChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .macStatus(macStatus),
  .sfIrqIn  (sfIrqIn),
  .cmdPulse (cmdPulse),
  .hostIrq  (hostIrq)
);

// File: tb/sim_hostRegFront.sv
module sim_hostRegFront;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] evtPulse = '0;
  logic [7:0] macStatus = 8'hA5;
  logic       sfIrqIn = 1'b0;
  logic [6:0] cmdPulse;
  logic       hostIrq;

  int checks = 0;
  int errors = 0;
  logic [6:0] pulseA, pulseB;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostRegFront u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .evtPulse(evtPulse), .macStatus(macStatus),
    .sfIrqIn(sfIrqIn), .cmdPulse(cmdPulse), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    pulseA = cmdPulse;
    wrEn = 1'b0;
    @(negedge clk);
    pulseB = cmdPulse;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulseEvt(input logic [7:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R1 R4 R6 R7 R12)
    check("R12 rdData reset", rdData, 8'h00);
    check("R7 hostIrq reset", {7'd0, hostIrq}, 8'h00);
    check("R3 cmdPulse reset", {1'b0, cmdPulse}, 8'h00);
    readReg(4'd1, rv); check("R1 page reset", rv, 8'h00);
    readReg(4'd6, rv); check("R4 status reset", rv, 8'h00);
    readReg(4'd7, rv); check("R6 global reset", rv, 8'h00);

    // R2: status port exhaustive
    for (int s = 0; s < 256; s++) begin
      macStatus = 8'(s);
      readReg(4'd0, rv); check("R2 status read", rv, 8'(s));
    end

    // R3: single command bits (bit1 soft reset left to later)
    for (int i = 0; i < 7; i++) begin
      if (i == 1) continue;
      writeReg(4'd0, 8'(1 << i));
      check("R3 pulse cycle", {1'b0, pulseA}, 8'(1 << i));
      check("R3 pulse ends", {1'b0, pulseB}, 8'h00);
    end
    writeReg(4'd0, 8'h80);
    check("R3 bit7 no effect", {1'b0, pulseA}, 8'h00);
    macStatus = 8'h3C;
    readReg(4'd0, rv); check("R2 write not readback", rv, 8'h3C);
    readReg(4'd6, rv); check("R8 force sets bit7", rv, 8'h80);

    // R10: soft reset clears everything
    writeReg(4'd1, 8'd1);
    writeReg(4'd12, 8'hFF);
    writeReg(4'd7, 8'h0A);
    pulseEvt(8'h21);
    writeReg(4'd1, 8'd5);
    writeReg(4'd0, 8'h02);
    check("R10 reset pulse", {1'b0, pulseA}, 8'h02);
    readReg(4'd1, rv); check("R10 page cleared", rv, 8'h00);
    readReg(4'd6, rv); check("R10 status cleared", rv, 8'h00);
    readReg(4'd7, rv); check("R10 global cleared", rv, 8'h00);
    writeReg(4'd1, 8'd1);
    readReg(4'd12, rv); check("R10 mask cleared", rv, 8'h00);

    // R9: enable latch off after reset
    writeReg(4'd12, 8'h01);
    pulseEvt(8'h01);
    check("R9 no irq without enable", {7'd0, hostIrq}, 8'h00);
    readReg(4'd7, rv); check("R9 eth pending gated", rv, 8'h00);
    writeReg(4'd0, 8'h04);
    check("R9 irq after enable", {7'd0, hostIrq}, 8'h01);
    readReg(4'd7, rv); check("R6 eth pending", rv, 8'h01);

    // R4: accumulate and write-one-to-clear
    writeReg(4'd6, 8'hFF);
    readReg(4'd6, rv); check("R4 clear all", rv, 8'h00);
    begin
      logic [7:0] acc;
      acc = 8'h00;
      for (int i = 0; i < 8; i++) begin
        pulseEvt(8'(1 << i));
        acc = (acc | 8'(1 << i)) & 8'hF7;
        readReg(4'd6, rv); check("R4 event sets", rv, acc);
      end
      writeReg(4'd6, 8'h00);
      readReg(4'd6, rv); check("R4 zero write no change", rv, 8'hF7);
      writeReg(4'd6, 8'h03);
      readReg(4'd6, rv); check("R4 partial clear", rv, 8'hF4);
    end
    // R4: set wins over clear on the same edge
    @(negedge clk);
    wrEn = 1'b1; regAddr = 4'd6; wrData = 8'h11; evtPulse = 8'h01;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = '0;
    readReg(4'd6, rv); check("R4 set beats clear", rv, 8'hE5);

    // R1/R11/R5: page sweep with mask 0x5A
    writeReg(4'd1, 8'd1);
    writeReg(4'd12, 8'h5A);
    check("R5 mask write pulse", {1'b0, pulseA}, 8'h00);
    for (int p = 0; p < 256; p++) begin
      writeReg(4'd1, 8'(p));
      readReg(4'd1, rv); check("R1 page readback", rv, 8'(p));
      readReg(4'd6, rv); check("R1 fixed status same", rv, 8'hE5);
      for (int o = 8; o < 16; o++) begin
        readReg(4'(o), rv);
        check("R11 paged decode", rv, (p == 1 && o == 12) ? 8'h5A : 8'h00);
      end
    end
    writeReg(4'd1, 8'd2);
    for (int o = 8; o < 16; o++) writeReg(4'(o), 8'hFF);
    writeReg(4'd1, 8'd1);
    for (int o = 8; o < 16; o++) if (o != 12) writeReg(4'(o), 8'hFF);
    for (int o = 2; o < 6; o++) writeReg(4'(o), 8'hFF);
    readReg(4'd12, rv); check("R11 writes ignored mask", rv, 8'h5A);
    readReg(4'd1, rv); check("R11 writes ignored page", rv, 8'h01);
    readReg(4'd6, rv); check("R11 writes ignored status", rv, 8'hE5);
    for (int o = 2; o < 6; o++) begin
      readReg(4'(o), rv); check("R11 gap reads zero", rv, 8'h00);
    end

    // R7: exhaustive mask sweep with status 0xF7
    pulseEvt(8'hFF);
    for (int m = 0; m < 256; m++) begin
      writeReg(4'd12, 8'(m));
      check("R7 mask sweep", {7'd0, hostIrq}, {7'd0, |(8'(m) & 8'hF7)});
    end
    // R7/R4: status patterns under full mask
    writeReg(4'd12, 8'hFF);
    for (int s = 0; s < 16; s++) begin
      logic [7:0] pat;
      pat = 8'(s * 37 + 8) & 8'hF7;
      writeReg(4'd6, 8'hFF);
      pulseEvt(pat);
      check("R7 status pattern", {7'd0, hostIrq}, {7'd0, |pat});
    end
    // R6/R7: global register sweep
    pulseEvt(8'h01);
    for (int pend = 0; pend < 2; pend++) begin
      writeReg(4'd12, pend == 1 ? 8'h01 : 8'h00);
      for (int g = 0; g < 16; g++) begin
        for (int sf = 0; sf < 2; sf++) begin
          logic expIrq;
          sfIrqIn = sf[0];
          writeReg(4'd7, 8'(g));
          expIrq = (pend[0] && !g[1]) || (sf[0] && !g[3]);
          check("R7 global sweep", {7'd0, hostIrq}, {7'd0, expIrq});
          readReg(4'd7, rv);
          check("R6 global read", rv, {4'd0, g[3], sf[0], g[1], pend[0]});
        end
      end
    end
    sfIrqIn = 1'b0;
    writeReg(4'd7, 8'h00);

    // R12: hold without read strobe
    readReg(4'd1, rv);
    @(negedge clk); regAddr = 4'd6;
    @(negedge clk);
    check("R12 hold", rdData, 8'h01);

    // R10: reset beats an event on its edge
    @(negedge clk);
    wrEn = 1'b1; regAddr = 4'd0; wrData = 8'h06;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = 8'h01;
    @(negedge clk);
    evtPulse = '0;
    readReg(4'd6, rv); check("R10 reset beats event", rv, 8'h00);
    writeReg(4'd1, 8'd1);
    writeReg(4'd12, 8'h01);
    pulseEvt(8'h01);
    check("R10 reset beats enable", {7'd0, hostIrq}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule